// File: doc/BRIEF.md
# Priority Transmit Mailbox Arbiter

This block decides which of a bank of message mailboxes a CAN-style frame transmitter sends next. Every mailbox has an enable bit, a direction bit, a transmit-request bit and a 6-bit transmit priority. A mailbox takes part in arbitration only when it is enabled, set for transmit, and has a request pending. The mailbox with the largest priority value wins. When two eligible mailboxes have the same priority, the higher-numbered one wins.

The transmitter sees the winner as an index with a valid flag. It accepts the winner with a start pulse. From then on the index is frozen until the transmitter returns a completion pulse. In that same clock edge the mailbox's request bit is cleared and its acknowledge bit is set. The host writes the enable and direction masks, each mailbox's control word, a write-one-to-set request register and a write-one-to-clear acknowledge register. All of these go through one write port with a select code.

Top module: `txPrioArbiter`

## Requirements
- R1: After reset, txValid, txIndex, txBusy, reqState and ackState are all 0, and every enable, direction and priority value is 0.
- R2: A mailbox is eligible only when all of these hold: its enable bit is 1, its direction bit is 0 (1 means receive), and its request bit is 1. Host select 0 writes the enable mask from hostData and select 1 writes the direction mask.
- R3: Among eligible mailboxes, the one with the numerically largest priority wins. Priority is taken from bits [13:8] of hostData on a control-word write (select 4) to the mailbox given by hostMbox.
- R4: If eligible mailboxes share the largest priority value, the highest-numbered one among them wins.
- R5: A write with select 2 sets the request bit of every mailbox whose hostData bit is 1. Bits written as 0 leave requests unchanged.
- R6: A txDone pulse while busy does three things on the same edge: it clears the held mailbox's request bit, sets its acknowledge bit, and drops txBusy. A host set of that request bit in the same cycle takes precedence.
- R7: A write with select 3 clears the acknowledge bits whose hostData bit is 1. Zero bits have no effect. A completion in the same cycle takes precedence.
- R8: When no mailbox is eligible and the block is not busy, txValid is 0 and txIndex is 0.
- R9: A txStart pulse while txValid=1 and not busy latches the current winner and raises txBusy. While busy, txValid stays 1 and txIndex does not change, even if masks, priorities or requests change.
- R10: txDone is ignored while not busy. txStart is ignored while busy or while no mailbox is eligible.
- R11: Clearing a mailbox's enable bit removes it from arbitration on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostSel | input | 3 | Write target: 0 enable, 1 direction, 2 request set, 3 acknowledge clear, 4 control word; others ignored |
| hostMbox | input | 5 | Mailbox addressed by a control-word write |
| hostData | input | 32 | Host write data |
| txStart | input | 1 | Transmitter accepts the current winner |
| txDone | input | 1 | Transmitter finished the held mailbox |
| txValid | output | 1 | A winner is present or a transmission is in progress |
| txIndex | output | 5 | Winning or held mailbox index |
| txBusy | output | 1 | Transmission in progress |
| reqState | output | 32 | Transmit-request bits |
| ackState | output | 32 | Acknowledge bits |

## Verification
The assertions check four properties on every cycle: the picked mailbox is eligible; no eligible mailbox beats it on priority or, at equal priority, on index; the index is frozen while busy; and an idle block with no eligible mailbox drives index 0. They also check that a completion leaves the acknowledge bit set and the request bit cleared one edge later, and that a transmission can only start from a valid winner. The bench's scenarios are needed to show that the host registers behave as write-one-to-set and write-one-to-clear with zero bits ignored, and that the direction and enable masks remove mailboxes from arbitration. The scenarios also exercise the precedence rules when host writes and completions collide. For this, random traffic with few priority levels produces many ties, and a bench model predicts every outcome.

// File: rtl/txArbPkg.sv
package txArbPkg;
  typedef enum logic [2:0] {
    SEL_ENABLE = 3'd0,
    SEL_DIR    = 3'd1,
    SEL_REQSET = 3'd2,
    SEL_ACKCLR = 3'd3,
    SEL_CTRL   = 3'd4
  } hostSel_e;

  typedef struct packed {
    logic latchWin;
    logic complete;
  } ctrlStb_t;
endpackage

// File: rtl/txPrioPicker.sv
module txPrioPicker #(
  parameter int NUM_MBOX = 32,
  parameter int PRIO_W   = 6,
  localparam int IDX_W   = $clog2(NUM_MBOX)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_MBOX-1:0]        eligMask,
  input  logic [NUM_MBOX*PRIO_W-1:0] prioFlat,
  output logic                       found,
  output logic [IDX_W-1:0]           winIdx
);
  logic [PRIO_W-1:0] bestPrio;

  // Ascending scan with >= lets a later (higher) index take ties.
  always_comb begin
    found    = 1'b0;
    winIdx   = '0;
    bestPrio = '0;
    for (int i = 0; i < NUM_MBOX; i++) begin
      if (eligMask[i] && (!found || prioFlat[i*PRIO_W +: PRIO_W] >= bestPrio)) begin
        found    = 1'b1;
        winIdx   = IDX_W'(i);
        bestPrio = prioFlat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  // Independent check: nobody eligible outranks the winner.
  logic beaten;
  always_comb begin
    beaten = 1'b0;
    for (int i = 0; i < NUM_MBOX; i++) begin
      if (eligMask[i] && found) begin
        if (prioFlat[i*PRIO_W +: PRIO_W] > prioFlat[winIdx*PRIO_W +: PRIO_W])
          beaten = 1'b1;
        if (prioFlat[i*PRIO_W +: PRIO_W] == prioFlat[winIdx*PRIO_W +: PRIO_W] &&
            IDX_W'(i) > winIdx)
          beaten = 1'b1;
      end
    end
  end

  p_winner_eligible_r2: assert property (@(posedge clk) disable iff (!rstN)
    found |-> eligMask[winIdx]);
  // covers the tie rule of R4 as well
  p_winner_best_r3: assert property (@(posedge clk) disable iff (!rstN)
    !beaten);
  p_found_any_r8: assert property (@(posedge clk) disable iff (!rstN)
    found == (|eligMask));
endmodule

// File: rtl/txArbControl.sv
module txArbControl
  import txArbPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     txStart,
  input  logic     txDone,
  input  logic     found,
  output logic     busy,
  output ctrlStb_t stb
);
  always_comb begin
    stb.latchWin = txStart && found && !busy;
    stb.complete = txDone && busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             busy <= 1'b0;
    else if (stb.latchWin) busy <= 1'b1;
    else if (stb.complete) busy <= 1'b0;
  end

  p_start_needs_winner_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(found) && $past(txStart));
  p_done_drops_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txDone) |=> !busy);
endmodule

// File: rtl/txArbDatapath.sv
module txArbDatapath
  import txArbPkg::*;
#(
  parameter int NUM_MBOX = 32,
  parameter int PRIO_W   = 6,
  parameter int DATA_W   = 32,
  parameter int PRIO_LSB = 8,
  localparam int IDX_W   = $clog2(NUM_MBOX)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWrEn,
  input  logic [2:0]          hostSel,
  input  logic [IDX_W-1:0]    hostMbox,
  input  logic [DATA_W-1:0]   hostData,
  input  logic                busy,
  input  ctrlStb_t            stb,
  output logic                found,
  output logic                txValid,
  output logic [IDX_W-1:0]    txIndex,
  output logic [NUM_MBOX-1:0] reqState,
  output logic [NUM_MBOX-1:0] ackState
);
  logic [NUM_MBOX-1:0]        enReg, dirReg, reqReg, ackReg;
  logic [NUM_MBOX-1:0]        setMask, clrMask, doneMask, eligMask;
  logic [NUM_MBOX*PRIO_W-1:0] prioFlat;
  logic [IDX_W-1:0]           heldIdx, winIdx;
  hostSel_e                   selCode;

  assign selCode  = hostSel_e'(hostSel);
  assign setMask  = (hostWrEn && selCode == SEL_REQSET) ? hostData[NUM_MBOX-1:0] : '0;
  assign clrMask  = (hostWrEn && selCode == SEL_ACKCLR) ? hostData[NUM_MBOX-1:0] : '0;
  assign doneMask = stb.complete ? (NUM_MBOX'(1) << heldIdx) : '0;
  assign eligMask = enReg & ~dirReg & reqReg;

  generate
    for (genvar g = 0; g < NUM_MBOX; g++) begin : gPrio
      logic [PRIO_W-1:0] prioReg;
      always_ff @(posedge clk) begin
        if (!rstN)
          prioReg <= '0;
        else if (hostWrEn && selCode == SEL_CTRL && hostMbox == IDX_W'(g))
          prioReg <= hostData[PRIO_LSB +: PRIO_W];
      end
      assign prioFlat[g*PRIO_W +: PRIO_W] = prioReg;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= '0;
      dirReg  <= '0;
      reqReg  <= '0;
      ackReg  <= '0;
      heldIdx <= '0;
    end else begin
      if (hostWrEn && selCode == SEL_ENABLE) enReg  <= hostData[NUM_MBOX-1:0];
      if (hostWrEn && selCode == SEL_DIR)    dirReg <= hostData[NUM_MBOX-1:0];
      reqReg <= (reqReg & ~doneMask) | setMask;
      ackReg <= (ackReg & ~clrMask) | doneMask;
      if (stb.latchWin) heldIdx <= winIdx;
    end
  end

  txPrioPicker #(.NUM_MBOX(NUM_MBOX), .PRIO_W(PRIO_W)) uPicker (
    .clk(clk), .rstN(rstN), .eligMask(eligMask), .prioFlat(prioFlat),
    .found(found), .winIdx(winIdx)
  );

  assign txValid  = busy | found;
  assign txIndex  = busy ? heldIdx : winIdx;
  assign reqState = reqReg;
  assign ackState = ackReg;

  p_done_sets_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.complete |=> ackReg[$past(heldIdx)]);
  p_done_clears_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.complete && !setMask[heldIdx]) |=> !reqReg[$past(heldIdx)]);
endmodule

// File: rtl/txPrioArbiter.sv
module txPrioArbiter
  import txArbPkg::*;
#(
  parameter int NUM_MBOX = 32,
  parameter int PRIO_W   = 6,
  parameter int DATA_W   = 32,
  parameter int PRIO_LSB = 8,
  localparam int IDX_W   = $clog2(NUM_MBOX)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWrEn,
  input  logic [2:0]          hostSel,
  input  logic [IDX_W-1:0]    hostMbox,
  input  logic [DATA_W-1:0]   hostData,
  input  logic                txStart,
  input  logic                txDone,
  output logic                txValid,
  output logic [IDX_W-1:0]    txIndex,
  output logic                txBusy,
  output logic [NUM_MBOX-1:0] reqState,
  output logic [NUM_MBOX-1:0] ackState
);
  ctrlStb_t stb;
  logic     found, busy;

  txArbControl uCtrl (
    .clk(clk), .rstN(rstN), .txStart(txStart), .txDone(txDone),
    .found(found), .busy(busy), .stb(stb)
  );

  txArbDatapath #(.NUM_MBOX(NUM_MBOX), .PRIO_W(PRIO_W), .DATA_W(DATA_W),
                  .PRIO_LSB(PRIO_LSB)) uDp (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostMbox(hostMbox), .hostData(hostData), .busy(busy), .stb(stb),
    .found(found), .txValid(txValid), .txIndex(txIndex),
    .reqState(reqState), .ackState(ackState)
  );

  assign txBusy = busy;

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !txValid |-> txIndex == '0);
  p_hold_index_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && $past(txBusy)) |-> (txIndex == $past(txIndex)) && txValid);
endmodule

// File: tb/tb_txPrioArbiter.sv
`timescale 1ns/1ps
module tb_txPrioArbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [2:0]  hostSel = '0;
  logic [4:0]  hostMbox = '0;
  logic [31:0] hostData = '0;
  logic        txStart = 1'b0, txDone = 1'b0;
  logic        txValid, txBusy;
  logic [4:0]  txIndex;
  logic [31:0] reqState, ackState;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  txPrioArbiter dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostMbox(hostMbox), .hostData(hostData), .txStart(txStart), .txDone(txDone),
    .txValid(txValid), .txIndex(txIndex), .txBusy(txBusy),
    .reqState(reqState), .ackState(ackState)
  );

  // reference model
  bit [31:0] mEn, mDir, mReq, mAck;
  bit [5:0]  mPrio [32];
  bit        mBusy;
  int        mHeld;

  function automatic void expWin(output bit f, output int idx);
    bit [5:0] best = 0;
    f = 0; idx = 0;
    for (int i = 0; i < 32; i++)
      if (mEn[i] && !mDir[i] && mReq[i] && (!f || mPrio[i] >= best)) begin
        f = 1; idx = i; best = mPrio[i];
      end
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit wr, input logic [2:0] sel, input logic [4:0] mb,
                      input logic [31:0] d, input bit st, input bit dn, input string tag);
    bit f; int w; bit lat, comp; bit [31:0] dm, sm, cm;
    bit eV; int eI;
    hostWrEn = wr; hostSel = sel; hostMbox = mb; hostData = d;
    txStart = st; txDone = dn;
    expWin(f, w);
    lat  = st && f && !mBusy;
    comp = dn && mBusy;
    dm = comp ? (32'd1 << mHeld) : 0;
    sm = (wr && sel == 3'd2) ? d : 0;
    cm = (wr && sel == 3'd3) ? d : 0;
    @(posedge clk);
    if (wr && sel == 3'd0) mEn = d;
    if (wr && sel == 3'd1) mDir = d;
    if (wr && sel == 3'd4) mPrio[mb] = d[13:8];
    mReq = (mReq & ~dm) | sm;
    mAck = (mAck & ~cm) | dm;
    if (lat) begin mBusy = 1; mHeld = w; end
    else if (comp) mBusy = 0;
    #1;
    hostWrEn = 0; txStart = 0; txDone = 0;
    expWin(f, w);
    eV = mBusy | f;
    eI = mBusy ? mHeld : (f ? w : 0);
    chk({tag, " txValid"}, {31'd0, txValid}, {31'd0, eV});
    chk({tag, " txIndex"}, {27'd0, txIndex}, eI);
    chk({tag, " txBusy"}, {31'd0, txBusy}, {31'd0, mBusy});
    chk({tag, " reqState"}, reqState, mReq);
    chk({tag, " ackState"}, ackState, mAck);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 txValid", {31'd0, txValid}, 0);
    chk("R1 txIndex", {27'd0, txIndex}, 0);
    chk("R1 txBusy", {31'd0, txBusy}, 0);
    chk("R1 reqState", reqState, 0);
    chk("R1 ackState", ackState, 0);
    rstN = 1'b1;

    step(1, 3'd0, 0, 32'h88, 0, 0, "R2 enable");
    step(1, 3'd4, 3, 32'h0500, 0, 0, "R3 prio");
    step(1, 3'd4, 7, 32'h0500, 0, 0, "R3 prio");
    step(1, 3'd2, 0, 32'h88, 0, 0, "R5 set");
    chk("R5 reqState after set", reqState, 32'h88);
    chk("R4 tie goes high", {27'd0, txIndex}, 7);
    step(1, 3'd2, 0, 32'h0, 0, 0, "R5 zero");
    chk("R5 zero write no effect", reqState, 32'h88);
    step(1, 3'd4, 3, 32'h0900, 0, 0, "R3 raise");
    chk("R3 larger prio wins", {27'd0, txIndex}, 3);
    step(1, 3'd1, 0, 32'h08, 0, 0, "R2 dir");
    chk("R2 receive mailbox excluded", {27'd0, txIndex}, 7);
    step(1, 3'd0, 0, 32'h08, 0, 0, "R11 disable");
    chk("R11 R8 no eligible valid", {31'd0, txValid}, 0);
    chk("R8 idle index", {27'd0, txIndex}, 0);
    step(1, 3'd0, 0, 32'h88, 0, 0, "R11 enable");
    step(1, 3'd1, 0, 32'h0, 0, 0, "R2 dir");
    step(0, 3'd0, 0, 32'h0, 1, 0, "R9 start");
    chk("R9 busy", {31'd0, txBusy}, 1);
    chk("R9 latched", {27'd0, txIndex}, 3);
    step(1, 3'd4, 7, 32'h3F00, 0, 0, "R9 hold");
    chk("R9 index held", {27'd0, txIndex}, 3);
    step(0, 3'd0, 0, 32'h0, 1, 0, "R10 start busy");
    chk("R10 start while busy keeps index", {27'd0, txIndex}, 3);
    step(0, 3'd0, 0, 32'h0, 0, 1, "R6 done");
    chk("R6 req cleared", reqState, 32'h80);
    chk("R6 ack set", ackState, 32'h08);
    chk("R6 busy dropped", {31'd0, txBusy}, 0);
    step(1, 3'd3, 0, 32'h0, 0, 0, "R7 zero");
    chk("R7 zero clear no effect", ackState, 32'h08);
    step(1, 3'd3, 0, 32'h08, 0, 0, "R7 clear");
    chk("R7 ack cleared", ackState, 32'h0);
    step(0, 3'd0, 0, 32'h0, 0, 1, "R10 done idle");
    chk("R10 done idle req", reqState, 32'h80);
    chk("R10 done idle ack", ackState, 32'h0);
    step(1, 3'd0, 0, 32'h0, 0, 0, "R11 disable all");
    step(0, 3'd0, 0, 32'h0, 1, 0, "R10 start none");
    chk("R10 start with none eligible", {31'd0, txBusy}, 0);

    // random traffic, few priority levels to force ties (R2 R3 R4 R5 R6 R7)
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] d;
      logic [2:0]  s;
      s = 3'($urandom_range(0, 5));
      d = $urandom;
      if (s == 3'd4) d[13:8] = ($urandom_range(0, 9) == 0) ? 6'h3F : 6'($urandom_range(0, 3));
      if (s == 3'd0) d = d | $urandom;
      if (s == 3'd1) d = d & $urandom & $urandom;
      if (s == 3'd2) d = d & $urandom;
      step($urandom_range(0, 3) != 0, s, 5'($urandom), d,
           $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, "R3 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule